// File: doc/BRIEF.md
# Data Translation Buffer with Fault Recording

This block is the data-side address translation buffer of a 64-bit core with 8 KB base pages. Every load or store presents a virtual address, the current context, a write flag and a user-mode flag. The address and context are compared against all stored entries at once. One cycle later the block returns a registered response. That response holds the physical address, the read and write permissions and a two-bit trap code, marked by a one-cycle valid strobe.

Entries are loaded through a write port that gives an index, a tag and a translation word. The tag holds the virtual page in its upper bits and the context in its low 13 bits. A readback port lets software see the stored translation word, including the used bit that the block sets on each clean hit.

When an access is refused or finds no entry, the block records what happened. It keeps three registers: a fault status word, a fault address and a tag-access word, the last holding the page and context that a refill handler needs. A fault that arrives while the previous one is still recorded marks overflow. Software clears the status word with a one-cycle clear pulse.

Top module: `dxb_translate`

## Requirements
- R1: After synchronous reset the response strobe is low, the status, fault-address and tag-access registers read zero, and every entry is invalid, so any lookup misses.
- R2: An entry matches when translation bit 63 (valid) is set, tag bits 63..13 equal address bits 63..13, and tag bits 12..0 equal the context. When several entries match, the lowest index is used. A written entry is visible to lookups from the cycle after the write.
- R3: A clean hit returns trap code 0 with read permission set, write permission equal to translation bit 1, and a physical address formed from translation bits 40..13 above address bits 12..0. The response appears on the clock edge that samples the request. Any trap returns both permissions low.
- R4: A clean hit sets bit 41 (used) of the stored translation word. A fault or a miss leaves that bit unchanged.
- R5: A user-mode access that hits an entry with translation bit 2 (privileged-only) set returns trap code 2, whether or not it is a write.
- R6: A write that hits an entry with translation bit 1 clear, and that is not a privilege violation, returns trap code 3.
- R7: On trap code 2 or 3 the status word is updated as follows. If its bit 0 is already set, it is first replaced by the value 2 (overflow). Then bit 0 (valid) is set, bit 2 takes the write flag, bit 3 takes the user flag, and bit 7 is set only for a privilege violation.
- R8: On trap code 2 or 3 the fault-address register takes the full 64-bit virtual address. A hit or a miss leaves it unchanged.
- R9: On any trap the tag-access register takes address bits 63..13 above the 13-bit context. A clean hit leaves it unchanged.
- R10: When no entry matches, the block returns trap code 1 and leaves the status and fault-address registers unchanged.
- R11: A clear pulse zeroes the status word. A fault in the same cycle builds on the cleared value, so it does not report overflow.
- R12: The response strobe is high for exactly the cycle after each request cycle and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag: virtual page in bits 63..13, context in bits 12..0 |
| wr_tte | input | 64 | Translation word to store |
| rd_idx | input | 6 | Entry index for readback |
| rd_tte | output | 64 | Stored translation word at rd_idx |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_ctx | input | 13 | Current context |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| stat_clr | input | 1 | Clear pulse for the status word |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_trap | output | 2 | 0 none, 1 miss, 2 access fault, 3 protection |
| resp_rd | output | 1 | Read permitted |
| resp_wr | output | 1 | Write permitted |
| resp_pa | output | 41 | Physical address |
| fsr | output | 16 | Fault status word |
| far | output | 64 | Fault address |
| tag_access | output | 64 | Page and context of the last trapping access |

## Verification
The assertions check properties on every cycle. The strobe follows only a request, and a trap never grants a permission. A recorded fault always leaves the status valid bit set, and a miss leaves the status and fault address untouched. The tag-access context always equals the trapping request's context, and a clean hit leaves the used bit set. Other behaviour shows only in the bench's scenarios. These are the lowest-index choice between duplicate matches, the exact overflow value, the composition of the physical address, the permission matrix across all flag combinations, and the merge of a clear with a same-cycle fault.

// File: rtl/dxb_pkg.sv
package dxb_pkg;
  localparam int TTE_W      = 64;
  localparam int VALID_BIT  = 63;
  localparam int USED_BIT   = 41;
  localparam int PRIV_BIT   = 2;
  localparam int WRITE_BIT  = 1;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_MISS  = 2'd1,
    TRAP_FAULT = 2'd2,
    TRAP_PROT  = 2'd3
  } trap_e;
endpackage

// File: rtl/dxb_entry_array.sv
module dxb_entry_array
  import dxb_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [VA_W-1:0]      wr_tag,
  input  logic [TTE_W-1:0]     wr_tte,
  input  logic                 set_used,
  input  logic [IDX_W-1:0]     used_idx,
  input  logic [VA_W-1:0]      look_va,
  input  logic [PAGE_BITS-1:0] look_ctx,
  output logic [ENTRIES-1:0]   match_vec,
  input  logic [IDX_W-1:0]     sel_idx,
  output logic [TTE_W-1:0]     sel_tte,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [TTE_W-1:0]     rd_tte
);
  logic [VA_W-1:0]  tag_q [ENTRIES];
  logic [TTE_W-1:0] tte_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        tte_q[g] <= '0;
        tag_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        tte_q[g] <= wr_tte;
        tag_q[g] <= wr_tag;
      end else if (set_used && used_idx == IDX_W'(g)) begin
        tte_q[g][USED_BIT] <= 1'b1;
      end
    end

    assign match_vec[g] = tte_q[g][VALID_BIT]
                       && (tag_q[g][VA_W-1:PAGE_BITS] == look_va[VA_W-1:PAGE_BITS])
                       && (tag_q[g][PAGE_BITS-1:0] == look_ctx);
  end

  assign sel_tte = tte_q[sel_idx];
  assign rd_tte  = tte_q[rd_idx];

  AST_USED_STICKS: assert property (@(posedge clk) disable iff (rst)
    (set_used && !(wr_en && wr_idx == used_idx)) |=> tte_q[$past(used_idx)][USED_BIT]); // R4
endmodule

// File: rtl/dxb_hit_select.sv
module dxb_hit_select #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  output logic               hit_any,
  output logic [IDX_W-1:0]   hit_idx
);
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end
  assign hit_any = |match_vec;

  always_comb begin
    if (hit_any) AST_SEL_IS_MATCH: assert (match_vec[hit_idx]); // R2
  end
endmodule

// File: rtl/dxb_fault_regs.sv
module dxb_fault_regs #(
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int FSR_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_fault,
  input  logic                 ev_miss,
  input  logic                 ev_priv,
  input  logic                 ev_user,
  input  logic                 ev_write,
  input  logic [VA_W-1:0]      ev_va,
  input  logic [PAGE_BITS-1:0] ev_ctx,
  input  logic                 clr,
  output logic [FSR_W-1:0]     fsr_q,
  output logic [VA_W-1:0]      far_q,
  output logic [VA_W-1:0]      tag_q
);
  logic [FSR_W-1:0] cur, base, nxt;

  always_comb begin
    cur    = clr ? '0 : fsr_q;
    base   = cur[0] ? FSR_W'(2) : cur;
    nxt    = base;
    nxt[0] = 1'b1;
    nxt[2] = base[2] | ev_write;
    nxt[3] = base[3] | ev_user;
    nxt[7] = base[7] | ev_priv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_q <= '0;
      far_q <= '0;
      tag_q <= '0;
    end else begin
      if (ev_fault) begin
        fsr_q <= nxt;
        far_q <= ev_va;
      end else if (clr) begin
        fsr_q <= '0;
      end
      if (ev_fault || ev_miss)
        tag_q <= {ev_va[VA_W-1:PAGE_BITS], ev_ctx};
    end
  end

  AST_FAULT_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    ev_fault |=> fsr_q[0]); // R7
  AST_MISS_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (ev_miss && !clr) |=> (fsr_q == $past(fsr_q)) && (far_q == $past(far_q))); // R10
  AST_FAR_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    ev_fault |=> far_q == $past(ev_va)); // R8
  AST_TAG_CTX: assert property (@(posedge clk) disable iff (rst)
    (ev_fault || ev_miss) |=> tag_q[PAGE_BITS-1:0] == $past(ev_ctx)); // R9
endmodule

// File: rtl/dxb_translate.sv
module dxb_translate
  import dxb_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int PPN_HI    = 40,
  parameter int FSR_W     = 16,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int PA_W     = PPN_HI + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [VA_W-1:0]      wr_tag,
  input  logic [TTE_W-1:0]     wr_tte,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [TTE_W-1:0]     rd_tte,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_va,
  input  logic [PAGE_BITS-1:0] req_ctx,
  input  logic                 req_write,
  input  logic                 req_user,
  input  logic                 stat_clr,
  output logic                 resp_valid,
  output logic [1:0]           resp_trap,
  output logic                 resp_rd,
  output logic                 resp_wr,
  output logic [PA_W-1:0]      resp_pa,
  output logic [FSR_W-1:0]     fsr,
  output logic [VA_W-1:0]      far,
  output logic [VA_W-1:0]      tag_access
);
  logic [ENTRIES-1:0] match_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [TTE_W-1:0]   hit_tte;
  logic               hit, miss, priv_f, prot_f, clean;
  trap_e              trap_d;

  dxb_entry_array #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_array (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tte(wr_tte),
    .set_used(clean), .used_idx(hit_idx),
    .look_va(req_va), .look_ctx(req_ctx), .match_vec(match_vec),
    .sel_idx(hit_idx), .sel_tte(hit_tte),
    .rd_idx(rd_idx), .rd_tte(rd_tte)
  );

  dxb_hit_select #(.ENTRIES(ENTRIES)) u_select (
    .match_vec(match_vec), .hit_any(hit_any), .hit_idx(hit_idx)
  );

  always_comb begin
    hit    = req_valid && hit_any;
    miss   = req_valid && !hit_any;
    priv_f = hit && req_user && hit_tte[PRIV_BIT];
    prot_f = hit && !priv_f && req_write && !hit_tte[WRITE_BIT];
    clean  = hit && !priv_f && !prot_f;
    if (miss)        trap_d = TRAP_MISS;
    else if (priv_f) trap_d = TRAP_FAULT;
    else if (prot_f) trap_d = TRAP_PROT;
    else             trap_d = TRAP_NONE;
  end

  dxb_fault_regs #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .FSR_W(FSR_W)) u_fault (
    .clk(clk), .rst(rst),
    .ev_fault(priv_f || prot_f), .ev_miss(miss), .ev_priv(priv_f),
    .ev_user(req_user), .ev_write(req_write),
    .ev_va(req_va), .ev_ctx(req_ctx), .clr(stat_clr),
    .fsr_q(fsr), .far_q(far), .tag_q(tag_access)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_trap  <= TRAP_NONE;
      resp_rd    <= 1'b0;
      resp_wr    <= 1'b0;
      resp_pa    <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_trap  <= trap_d;
      resp_rd    <= clean;
      resp_wr    <= clean && hit_tte[WRITE_BIT];
      resp_pa    <= clean ? {hit_tte[PPN_HI:PAGE_BITS], req_va[PAGE_BITS-1:0]} : '0;
    end
  end

  AST_STROBE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid)); // R12
  AST_TRAP_NO_PERM: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_trap != TRAP_NONE) |-> (!resp_rd && !resp_wr)); // R3
  AST_WR_IMPLIES_RD: assert property (@(posedge clk) disable iff (rst)
    resp_wr |-> resp_rd); // R3
  AST_IDLE_NO_PERM: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> (!resp_rd && !resp_wr)); // R12
endmodule

// File: tb/dxb_translate_bench.sv
module dxb_translate_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [5:0]  wr_idx, rd_idx;
  logic [63:0] wr_tag, wr_tte, rd_tte;
  logic        req_valid, req_write, req_user, stat_clr;
  logic [63:0] req_va;
  logic [12:0] req_ctx;
  logic        resp_valid, resp_rd, resp_wr;
  logic [1:0]  resp_trap;
  logic [40:0] resp_pa;
  logic [15:0] fsr;
  logic [63:0] far, tag_access;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dxb_translate u_dxb_translate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_tte(wr_tte), .rd_idx(rd_idx), .rd_tte(rd_tte), .req_valid(req_valid),
    .req_va(req_va), .req_ctx(req_ctx), .req_write(req_write),
    .req_user(req_user), .stat_clr(stat_clr), .resp_valid(resp_valid),
    .resp_trap(resp_trap), .resp_rd(resp_rd), .resp_wr(resp_wr),
    .resp_pa(resp_pa), .fsr(fsr), .far(far), .tag_access(tag_access)
  );

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_tte(input logic [27:0] ppn, input bit priv, input bit wr);
    return (64'd1 << 63) | ({36'd0, ppn} << 13) | (64'(priv) << 2) | (64'(wr) << 1);
  endfunction

  task automatic put(input int idx, input logic [63:0] tag, input logic [63:0] tte);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_tag = tag; wr_tte = tte;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [63:0] va, input logic [12:0] ctx,
                      input bit w, input bit u, input bit clr);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_ctx = ctx; req_write = w; req_user = u;
    stat_clr = clr;
    @(posedge clk);
    #1;
    @(negedge clk);
    req_valid = 1'b0; stat_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] base_va;
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_tag = '0; wr_tte = '0; rd_idx = '0;
    req_valid = 1'b0; req_va = '0; req_ctx = '0; req_write = 1'b0; req_user = 1'b0;
    stat_clr = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 strobe", 64'(resp_valid), 0);
    check("R1 fsr", 64'(fsr), 0);
    check("R1 far", far, 0);
    check("R1 tag_access", tag_access, 0);
    look(64'h0, 13'h0, 0, 0, 0);
    check("R1 lookup misses", 64'(resp_trap), 1);

    // R2 / R3 sweep: each entry its own page and context
    base_va = 64'h0000_0ABC_0000_0000;
    for (int i = 0; i < 64; i++)
      put(i, (base_va + (64'(i) << 13)) | 64'(i + 5), mk_tte(28'(i + 100), 0, 1));
    for (int i = 0; i < 64; i++) begin
      look(base_va + (64'(i) << 13) + 64'h155, 13'(i + 5), 1, 1, 0);
      check("R3 sweep trap", 64'(resp_trap), 0);
      check("R3 sweep pa", 64'(resp_pa), (64'(i + 100) << 13) | 64'h155);
    end
    // R2 wrong context misses, R10 miss keeps status
    look(base_va, 13'h1FFF, 0, 0, 0);
    check("R2 ctx mismatch", 64'(resp_trap), 1);
    check("R10 fsr unchanged", 64'(fsr), 0);
    check("R10 far unchanged", far, 0);
    check("R9 tag on miss", tag_access, base_va | 64'h1FFF);

    // R5 R6 R3 R4 R7 R8: permission matrix on entry 5
    for (int m = 0; m < 16; m++) begin
      bit pv, wb, u, w, ep, ex;
      logic [1:0] et;
      logic [63:0] va;
      pv = m[0]; wb = m[1]; u = m[2]; w = m[3];
      va = 64'h1234_5678_9ABC_C000 + 64'(m * 3);
      put(5, {va[63:13], 13'h0042}, mk_tte(28'h0ABCDEF, pv, wb));
      ep = u && pv;
      ex = !ep && w && !wb;
      et = ep ? 2'd2 : (ex ? 2'd3 : 2'd0);
      look(va, 13'h0042, w, u, 1);
      check("R5/R6 trap", 64'(resp_trap), 64'(et));
      check("R3 rd", 64'(resp_rd), 64'(et == 0));
      check("R3 wr", 64'(resp_wr), 64'(et == 0 && wb));
      if (et == 0) check("R3 pa", 64'(resp_pa), (64'h0ABCDEF << 13) | 64'(va[12:0]));
      rd_idx = 6'd5; #1;
      check("R4 used bit", 64'(rd_tte[41]), 64'(et == 0));
      if (et != 0) begin
        check("R7 fresh fsr", 64'(fsr),
              64'(ep) << 7 | 64'(u) << 3 | 64'(w) << 2 | 64'd1);
        check("R8 far", far, va);
        check("R9 tag on fault", tag_access, {va[63:13], 13'h0042});
      end
    end

    // R7 overflow: fault, then second fault without clear
    put(7, 64'h0000_0000_0040_0000 | 64'h11, mk_tte(28'h5, 1, 0));
    look(64'h0000_0000_0040_0010, 13'h11, 0, 1, 1);
    check("R7 first fault", 64'(fsr), 64'h89);
    look(64'h0000_0000_0040_0020, 13'h11, 1, 0, 0);
    check("R6 prot trap", 64'(resp_trap), 3);
    check("R7 overflow value", 64'(fsr), 64'h7);
    // R10 miss after fault
    look(64'hFFFF_0000_0000_2000, 13'h3, 0, 0, 0);
    check("R10 miss trap", 64'(resp_trap), 1);
    check("R10 fsr held", 64'(fsr), 64'h7);
    check("R8 far held on miss", far, 64'h0000_0000_0040_0020);
    check("R9 tag after miss", tag_access, 64'hFFFF_0000_0000_2003);
    // R11 clear merged with a fault
    look(64'h0000_0000_0040_0030, 13'h11, 0, 1, 1);
    check("R11 clear+fault no overflow", 64'(fsr), 64'h89);
    look(64'h0, 13'h0, 0, 0, 1);
    check("R11 clear alone", 64'(fsr), 64'h0);

    // R2 lowest index wins, valid bit required
    put(10, 64'h0000_7000_0000_0000 | 64'h9, mk_tte(28'h222, 0, 1));
    put(3,  64'h0000_7000_0000_0000 | 64'h9, mk_tte(28'h111, 0, 1));
    look(64'h0000_7000_0000_0004, 13'h9, 0, 0, 0);
    check("R2 lowest index", 64'(resp_pa), (64'h111 << 13) | 64'h4);
    put(20, 64'h0000_7100_0000_0000, mk_tte(28'h1, 0, 1) & ~(64'd1 << 63));
    look(64'h0000_7100_0000_0000, 13'h0, 0, 0, 0);
    check("R2 invalid entry misses", 64'(resp_trap), 1);

    // R12 strobe only in the cycle after a request
    @(negedge clk); req_valid = 1'b1; req_va = 64'h0; req_ctx = '0;
    @(negedge clk); req_valid = 1'b0;
    check("R12 strobe high", 64'(resp_valid), 1);
    @(negedge clk);
    check("R12 strobe drops", 64'(resp_valid), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule